// File: doc/BRIEF.md
# DAC Settling-Time Stimulus and Strobe Generator

This block sits beside a converter under test and drives its digital input with a square pattern of full-scale steps. The code flips between a low code (only bit 0 set) and a high code (every active bit set), and it holds each code for a fixed number of reference-clock cycles. One such stretch is one code period. A single-cycle sampling strobe is raised in each code period at a programmed number of reference cycles after the step. An external track/hold and an averaging voltmeter use this strobe. Each period repeats the same timing, so the external average sees the output voltage at one fixed point after the step.

To trace the settling trajectory, the delay is swept one reference cycle at a time. A direction selector limits the strobe to rising steps, to falling steps, or allows both. The delay, direction and active code width are captured only at a code transition. A setting change therefore never shortens, moves or duplicates the strobe of the period already in progress.

Top module: `settle_pattern_gen`

## Requirements
- R1: While `enable` is low, or while reset is held, `dac_code` equals 1 and `sample_strobe` stays low, whatever the other inputs do. Dropping `enable` returns the block to this state at the next clock edge.
- R2: The first clock edge that samples `enable` high makes a rising step. In the cycle after that edge, `dac_code` shows the high code.
- R3: While enabled, each code is held for exactly PERIOD_CYC clock cycles, and the code then alternates between the low code (value 1) and the high code.
- R4: A strobe occurs in the cycle whose index after the step equals the captured delay. Index 0 is the cycle in which the new code first appears.
- R5: A `delay_sel` value above PERIOD_CYC-1 is treated as PERIOD_CYC-1.
- R6: The `strobe_edge` encoding is as follows. 2'b01 strobes only on rising steps, which are steps to the high code. 2'b10 strobes only on falling steps. 2'b00 and 2'b11 strobe on both.
- R7: A change of `delay_sel`, `strobe_edge` or `width_sel` during a code period does not affect that period. It applies from the next step.
- R8: The high code has its lowest W bits set and all other bits clear. W is `width_sel` limited to the range 2 to CODE_W.
- R9: The strobe is one cycle wide. Each enabled direction produces exactly one strobe per code period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that times the code period and the strobe delay |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the pattern while high |
| delay_sel | input | DLY_W | Strobe delay after each step, in clock cycles |
| strobe_edge | input | 2 | Step direction(s) that receive a strobe |
| width_sel | input | WID_W | Number of active code bits |
| dac_code | output | CODE_W | Code presented to the converter |
| sample_strobe | output | 1 | One-cycle sampling pulse for the track/hold |

## Verification
The hardest situation to reach is a settings update that lands inside a running code period. In that case the old delay, direction and width must still govern the remainder of the period, and the new ones must apply from the following step. The stimulus starts a run and changes all three settings two cycles after the first step. It then follows four whole periods and predicts each cycle's code and strobe from the old settings for the first period and the new ones afterwards. Clamping of out-of-range delay and width values is reached by table entries whose settings lie beyond the limits.

// File: rtl/settle_pkg.sv
// Shared types and helpers for the settling-time stimulus generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package settle_pkg;

    // Direction filter for the sampling strobe
    typedef enum logic [1:0] {
        STB_ANY     = 2'b00,
        STB_RISE    = 2'b01,
        STB_FALL    = 2'b10,
        STB_ANY_ALT = 2'b11
    } stb_mode_e;

    // True when a step of the given direction should receive a strobe
    function automatic logic edge_wanted(input stb_mode_e mode, input logic rising);
        case (mode)
            STB_RISE: return rising;
            STB_FALL: return !rising;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/settle_phase_timer.sv
// Phase counter for the code pattern.
// Counts reference cycles inside one code period and flips the level at the
// end of each period. It raises `step` in the cycle whose closing edge makes
// a code transition.
// Assumes PERIOD_CYC >= 2.
module settle_phase_timer #(
    parameter int PERIOD_CYC = 16,
    parameter int PH_W       = $clog2(PERIOD_CYC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    output logic            step,
    output logic [PH_W-1:0] phase_q,
    output logic            lvl_q,
    output logic            run_q
);

    localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD_CYC - 1);

    // A transition happens at start-up or at the last cycle of a period
    always_comb step = en && (!run_q || phase_q == LAST);

    // Advance the phase, flip the level on each step, idle when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            run_q   <= 1'b0;
            phase_q <= '0;
            lvl_q   <= 1'b0;
        end else if (step) begin
            run_q   <= 1'b1;
            phase_q <= '0;
            lvl_q   <= run_q ? ~lvl_q : 1'b1;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // R3: the end of a period flips the level and restarts the phase
    a_r3_period_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && en && phase_q == LAST) |=> (run_q && phase_q == '0 && lvl_q != $past(lvl_q)));

    // R2: start-up always begins with a rising step
    a_r2_first_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && en) |=> (run_q && lvl_q && phase_q == '0));

    // R1: disabling stops the pattern at the next edge
    a_r1_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !run_q);

endmodule

// File: rtl/settle_cfg_latch.sv
// Setting capture: clamps delay and width and holds them, with the strobe
// direction, from one code transition to the next.
// Assumes `step` is high only in the cycle that closes a code period.
module settle_cfg_latch
    import settle_pkg::*;
#(
    parameter int PERIOD_CYC = 16,
    parameter int CODE_W     = 12,
    parameter int DLY_W      = 6,
    parameter int WID_W      = 4,
    parameter int PH_W       = $clog2(PERIOD_CYC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [DLY_W-1:0] dly_in,
    input  logic [1:0]       mode_in,
    input  logic [WID_W-1:0] wid_in,
    output logic [PH_W-1:0]  dly_q,
    output stb_mode_e        mode_q,
    output logic [WID_W-1:0] wid_q
);

    localparam logic [PH_W-1:0]  DLY_MAX = PH_W'(PERIOD_CYC - 1);
    localparam logic [WID_W-1:0] WID_MAX = WID_W'(CODE_W);
    localparam logic [WID_W-1:0] WID_MIN = WID_W'(2);

    logic [PH_W-1:0]  dly_c;
    logic [WID_W-1:0] wid_c;

    // Limit the requested delay to the last cycle of a period
    always_comb dly_c = (int'(dly_in) > PERIOD_CYC - 1) ? DLY_MAX : PH_W'(dly_in);

    // Limit the requested width to the range 2..CODE_W
    always_comb begin
        if (wid_in < WID_MIN)             wid_c = WID_MIN;
        else if (int'(wid_in) > CODE_W)   wid_c = WID_MAX;
        else                              wid_c = wid_in;
    end

    // Capture the settings only at a code transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q  <= '0;
            mode_q <= STB_ANY;
            wid_q  <= WID_MAX;
        end else if (step) begin
            dly_q  <= dly_c;
            mode_q <= stb_mode_e'(mode_in);
            wid_q  <= wid_c;
        end
    end

    // R7: settings do not move between transitions
    a_r7_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(dly_q) && $stable(mode_q) && $stable(wid_q)));

    // R5: the captured delay never exceeds the period
    a_r5_delay_limit: assert property (@(posedge clk) disable iff (!rst_n)
        dly_q <= DLY_MAX);

    // R8: the captured width stays in its legal range
    a_r8_width_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (wid_q >= WID_MIN) && (wid_q <= WID_MAX));

endmodule

// File: rtl/settle_code_former.sv
// Code former: turns the level and captured width into the converter code.
// The low code is 1. The high code has the lowest `wid` bits set.
// Assumes 2 <= wid <= CODE_W.
module settle_code_former #(
    parameter int CODE_W = 12,
    parameter int WID_W  = 4
) (
    input  logic              run,
    input  logic              lvl,
    input  logic [WID_W-1:0]  wid,
    output logic [CODE_W-1:0] code
);

    logic [CODE_W-1:0] mask;

    // Build the active-bit mask for the captured width
    always_comb begin
        for (int i = 0; i < CODE_W; i++) mask[i] = (i < int'(wid));
    end

    // Select the high code only while running at the high level
    always_comb code = (run && lvl) ? mask : CODE_W'(1);

endmodule

// File: rtl/settle_strobe_gen.sv
// Strobe generator: one pulse per period at the captured delay, filtered by
// step direction.
// Assumes phase restarts at 0 in the cycle the new code first appears.
module settle_strobe_gen
    import settle_pkg::*;
#(
    parameter int PH_W = 4
) (
    input  logic            run,
    input  logic            lvl,
    input  logic [PH_W-1:0] phase,
    input  logic [PH_W-1:0] dly,
    input  stb_mode_e       mode,
    output logic            strobe
);

    // Fire when the phase reaches the delay on a wanted step direction
    always_comb strobe = run && (phase == dly) && edge_wanted(mode, lvl);

endmodule

// File: rtl/settle_pattern_gen.sv
// Top of the settling-time stimulus generator.
// Drives a full-scale alternating code and a delayed sampling strobe for a
// converter under test. The code period and strobe delay are counted in `clk`
// cycles. Outputs are decoded from flops in the same clock domain.
// Assumes PERIOD_CYC >= 2 and CODE_W >= 2.
module settle_pattern_gen
    import settle_pkg::*;
#(
    parameter int CODE_W     = 12,
    parameter int PERIOD_CYC = 16,
    parameter int DLY_W      = $clog2(PERIOD_CYC) + 2,
    parameter int WID_W      = $clog2(CODE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DLY_W-1:0]  delay_sel,
    input  logic [1:0]        strobe_edge,
    input  logic [WID_W-1:0]  width_sel,
    output logic [CODE_W-1:0] dac_code,
    output logic              sample_strobe
);

    localparam int PH_W = $clog2(PERIOD_CYC);

    logic             step;
    logic [PH_W-1:0]  phase_q;
    logic             lvl_q;
    logic             run_q;
    logic [PH_W-1:0]  dly_q;
    stb_mode_e        mode_q;
    logic [WID_W-1:0] wid_q;

    settle_phase_timer #(.PERIOD_CYC(PERIOD_CYC), .PH_W(PH_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(enable), .step(step),
        .phase_q(phase_q), .lvl_q(lvl_q), .run_q(run_q)
    );

    settle_cfg_latch #(
        .PERIOD_CYC(PERIOD_CYC), .CODE_W(CODE_W), .DLY_W(DLY_W),
        .WID_W(WID_W), .PH_W(PH_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .step(step), .dly_in(delay_sel),
        .mode_in(strobe_edge), .wid_in(width_sel),
        .dly_q(dly_q), .mode_q(mode_q), .wid_q(wid_q)
    );

    settle_code_former #(.CODE_W(CODE_W), .WID_W(WID_W)) u_code (
        .run(run_q), .lvl(lvl_q), .wid(wid_q), .code(dac_code)
    );

    settle_strobe_gen #(.PH_W(PH_W)) u_stb (
        .run(run_q), .lvl(lvl_q), .phase(phase_q), .dly(dly_q),
        .mode(mode_q), .strobe(sample_strobe)
    );

    // R1: idle outputs are the low code and no strobe
    a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (dac_code == CODE_W'(1) && !sample_strobe));

    // R8: the high code has exactly the captured number of bits, from bit 0
    a_r8_high_code_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && lvl_q) |-> ($countones(dac_code) == int'(wid_q) && dac_code[0]));

    // R9: the strobe never lasts two cycles
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strobe |=> !sample_strobe);

    // R6: rising-only mode strobes only while the high code is shown
    a_r6_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_strobe && mode_q == STB_RISE) |-> (dac_code != CODE_W'(1)));

endmodule

// File: tb/settle_pattern_gen_tb.sv
module settle_pattern_gen_tb;

    localparam int P  = 16;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [5:0]    delay_sel = '0;
    logic [1:0]    strobe_edge = '0;
    logic [3:0]    width_sel = 4'd12;
    logic [CW-1:0] dac_code;
    logic          sample_strobe;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    settle_pattern_gen u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .delay_sel(delay_sel),
        .strobe_edge(strobe_edge), .width_sel(width_sel),
        .dac_code(dac_code), .sample_strobe(sample_strobe)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [5:0] dly;
        logic [1:0] mode;
        logic [3:0] wid;
        logic [4:0] edly;
        logic [3:0] ewid;
        logic       rok;
        logic       fok;
    } vec_t;

    // dly, mode, wid -> expected delay, expected width, rise strobe, fall strobe
    localparam vec_t VECS [6] = '{
        '{6'd3,  2'd0, 4'd12, 5'd3,  4'd12, 1'b1, 1'b1},  // both steps
        '{6'd0,  2'd1, 4'd8,  5'd0,  4'd8,  1'b1, 1'b0},  // R6 rise only, delay 0
        '{6'd15, 2'd2, 4'd4,  5'd15, 4'd4,  1'b0, 1'b1},  // R6 fall only, last cycle
        '{6'd40, 2'd3, 4'd12, 5'd15, 4'd12, 1'b1, 1'b1},  // R5 delay clamp
        '{6'd7,  2'd0, 4'd0,  5'd7,  4'd2,  1'b1, 1'b1},  // R8 width raised to 2
        '{6'd9,  2'd1, 4'd15, 5'd9,  4'd12, 1'b1, 1'b0}   // R8 width cut to CODE_W
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Run four periods and compare every cycle against the model
    task automatic run_vec(input vec_t v);
        int code_bad = 0, stb_bad = 0, stb_cnt = 0;
        int first_code = 0, bad_act = 0, bad_exp = 0;
        @(negedge clk);
        enable = 1'b0;
        delay_sel = v.dly; strobe_edge = v.mode; width_sel = v.wid;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        for (int k = 0; k < 4 * P; k++) begin
            int ph, ecode;
            bit hi, estb;
            @(negedge clk);
            ph = k % P;
            hi = ((k / P) % 2) == 0;
            ecode = hi ? ((1 << int'(v.ewid)) - 1) : 1;
            estb = (ph == int'(v.edly)) && (hi ? v.rok : v.fok);
            if (k == 0) first_code = int'(dac_code);
            if (int'(dac_code) != ecode) begin
                if (code_bad == 0) begin bad_act = int'(dac_code); bad_exp = ecode; end
                code_bad++;
            end
            if (sample_strobe != estb) stb_bad++;
            if (sample_strobe) stb_cnt++;
        end
        chk(first_code == (1 << int'(v.ewid)) - 1, "R2 first code high", first_code,
            (1 << int'(v.ewid)) - 1);
        chk(code_bad == 0, "R3 R8 code pattern", bad_act, bad_exp);
        chk(stb_bad == 0, "R4 R5 R6 strobe timing", stb_bad, 0);
        chk(stb_cnt == 2 * int'(v.rok) + 2 * int'(v.fok), "R9 strobe count", stb_cnt,
            2 * int'(v.rok) + 2 * int'(v.fok));
        enable = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(dac_code == 1 && !sample_strobe, "R1 reset outputs", int'(dac_code), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(dac_code == 1 && !sample_strobe, "R1 idle after reset", int'(dac_code), 1);

        for (int i = 0; i < 6; i++) run_vec(VECS[i]);

        // R7: settings changed two cycles into the first period
        begin
            int bad = 0, cnt = 0;
            @(negedge clk);
            enable = 1'b0; delay_sel = 6'd5; strobe_edge = 2'd0; width_sel = 4'd12;
            repeat (2) @(negedge clk);
            enable = 1'b1;
            for (int k = 0; k < 4 * P; k++) begin
                int ph, idx, ecode, ed;
                bit hi, estb;
                @(negedge clk);
                ph = k % P; idx = k / P; hi = (idx % 2) == 0;
                if (idx == 0) begin
                    ecode = 12'hFFF; ed = 5; estb = (ph == ed);
                end else begin
                    ecode = hi ? 6'h3F : 1; ed = 10; estb = (ph == ed) && !hi;
                end
                if (int'(dac_code) != ecode || sample_strobe != estb) bad++;
                if (sample_strobe) cnt++;
                if (k == 2) begin
                    delay_sel = 6'd10; strobe_edge = 2'd2; width_sel = 4'd6;
                end
            end
            chk(bad == 0, "R7 mid-period change deferred", bad, 0);
            chk(cnt == 3, "R7 R9 strobe count across change", cnt, 3);

            // R1: disabling mid-period returns to idle at the next edge
            repeat (3) @(negedge clk);
            enable = 1'b0;
            @(negedge clk);
            chk(dac_code == 1 && !sample_strobe, "R1 stop on disable", int'(dac_code), 1);

            // R1: settings applied while idle create no strobe
            delay_sel = 6'd0; strobe_edge = 2'd0;
            cnt = 0;
            for (int k = 0; k < 2 * P; k++) begin
                @(negedge clk);
                if (sample_strobe || dac_code != 1) cnt++;
            end
            chk(cnt == 0, "R1 idle ignores settings", cnt, 0);

            // R1: reset in the middle of a run
            enable = 1'b1;
            repeat (5) @(negedge clk);
            rst_n = 1'b0;
            @(negedge clk);
            chk(dac_code == 1 && !sample_strobe, "R1 reset during run", int'(dac_code), 1);
            rst_n = 1'b1;
            enable = 1'b0;
            @(negedge clk);
        end
        finish_run();
    end

endmodule